// File: doc/BRIEF.md
# I/O Port Permission Checker

This block decides whether a guest's I/O port access must leave the guest and go to the host. Every port has one bit in a permission bitmap in memory. When an access arrives, the block latches the port number, the access descriptor, the bitmap base and the next-instruction address. It then issues a single 16-bit read through a request/response memory port.

An access can be 1 to 7 bytes wide. It covers that many consecutive port bits, and those bits may run across a byte boundary. The block therefore tests a shifted multi-bit window of the returned 16-bit word. It reports the result with a one-cycle `done` pulse. On an exit it also supplies the exit code and the two exit information words.

When the general I/O intercept enable is clear, the access is allowed at once and no memory read is made.

Top module: `io_perm_check`

## Requirements
- R1: After reset, `done`, `exit_req`, `busy` and `mem_req_valid` are 0.
- R2: A `start` with `io_icpt_en` at 0 makes no memory request. It gives `done`=1 with `exit_req`=0 in the cycle after `start`, and all exit fields are 0.
- R3: With the intercept enabled, the read address is the bitmap base plus the port number shifted right by 3.
- R4: `mem_req_valid` rises in the cycle after `start` and stays high with a stable address until a cycle with `mem_req_ready` high. It is low in the cycle after that.
- R5: The access size is descriptor bits 6:4. The exit decision is 1 when any of the word bits from `port[2:0]` up to `port[2:0]`+size−1 is set. Word bits outside that window have no effect, and a size of 0 never intercepts.
- R6: `done` is high for exactly one cycle, the cycle after `mem_rsp_valid` is seen while waiting. It stays low before then.
- R7: On an exit, `exit_info1` is the 32-bit descriptor ORed with the port number shifted left by 16, zero-extended to 64 bits.
- R8: On an exit, `exit_info2` is the next-instruction address latched at `start`, and `exit_code` is 0x7B. When there is no exit, both fields and `exit_info1` read 0.
- R9: Inputs are sampled only when `start` is accepted while idle. Changes afterwards, and any `start` while `busy`, do not affect the request or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check (accepted while idle) |
| port_num | input | 16 | Accessed I/O port |
| access_desc | input | 32 | Access descriptor, size in bits 6:4 |
| bitmap_base | input | 64 | Base address of the permission bitmap |
| next_ip | input | 64 | Address of the next instruction |
| io_icpt_en | input | 1 | General I/O intercept enable |
| busy | output | 1 | A check is in progress |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the 16-bit read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 16 | Read data word |
| done | output | 1 | One-cycle decision pulse |
| exit_req | output | 1 | Access must exit (valid with done) |
| exit_code | output | 32 | Exit code on an exit |
| exit_info1 | output | 64 | Descriptor with port in bits 31:16 |
| exit_info2 | output | 64 | Next-instruction address |

## Verification
The bench targets windows that straddle the byte boundary, such as port offset 7 with a 4-byte access. A design that shifts only within one byte would miss bit 8 or higher and let such an access through. Size 0 and words whose set bits lie just outside the window are tested as well: an off-by-one mask would raise false exits there. Long ready and response stalls, inputs that change mid-check and a stray `start` while busy are also exercised. These catch a design that drops the request, re-samples its inputs or restarts.

// File: rtl/io_perm_check.sv
module io_perm_check #(
  parameter int ADDR_W = 64,
  parameter int INFO_W = 64,
  parameter int DESC_W = 32,
  parameter int CODE_W = 32,
  parameter logic [CODE_W-1:0] IO_EXIT_CODE = 32'h7B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       port_num,
  input  logic [DESC_W-1:0] access_desc,
  input  logic [ADDR_W-1:0] bitmap_base,
  input  logic [ADDR_W-1:0] next_ip,
  input  logic              io_icpt_en,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [15:0]       mem_rsp_data,
  output logic              done,
  output logic              exit_req,
  output logic [CODE_W-1:0] exit_code,
  output logic [INFO_W-1:0] exit_info1,
  output logic [INFO_W-1:0] exit_info2
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;
  state_t state;

  logic [15:0]       port_q;
  logic [DESC_W-1:0] desc_q;
  logic [ADDR_W-1:0] addr_q, nip_q;

  logic [7:0]  size_mask;
  logic [15:0] window;
  logic        hit;

  assign size_mask = 8'((9'd1 << desc_q[6:4]) - 9'd1);
  assign window = {8'h00, size_mask} << port_q[2:0];
  assign hit = |(mem_rsp_data & window);

  assign busy = (state != S_IDLE);
  assign mem_req_valid = (state == S_REQ);
  assign mem_req_addr = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      port_q <= '0;
      desc_q <= '0;
      addr_q <= '0;
      nip_q <= '0;
      done <= 1'b0;
      exit_req <= 1'b0;
      exit_code <= '0;
      exit_info1 <= '0;
      exit_info2 <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          port_q <= port_num;
          desc_q <= access_desc;
          nip_q <= next_ip;
          addr_q <= bitmap_base + ADDR_W'(port_num[15:3]);
          if (io_icpt_en) begin
            state <= S_REQ;
          end else begin
            done <= 1'b1;
            exit_req <= 1'b0;
            exit_code <= '0;
            exit_info1 <= '0;
            exit_info2 <= '0;
          end
        end
        S_REQ: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          state <= S_IDLE;
          done <= 1'b1;
          exit_req <= hit;
          exit_code <= hit ? IO_EXIT_CODE : '0;
          exit_info1 <= hit ? INFO_W'(desc_q | (DESC_W'(port_q) << 16)) : '0;
          exit_info2 <= hit ? INFO_W'(nip_q) : '0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  a_r4_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_no_read_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && !io_icpt_en |=> done && !exit_req && !mem_req_valid);
  a_r6_done_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_req_valid && mem_rsp_valid |=> done && !busy);
  a_r8_exit_code: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req && done |-> exit_code == IO_EXIT_CODE);
endmodule

// File: tb/io_perm_check_test.sv
module io_perm_check_test;
  logic clk = 0, rst_n = 0, start = 0, io_icpt_en = 0;
  logic [15:0] port_num = 0, mem_rsp_data = 0;
  logic [31:0] access_desc = 0;
  logic [63:0] bitmap_base = 0, next_ip = 0;
  logic mem_req_ready = 0, mem_rsp_valid = 0;
  logic busy, mem_req_valid, done, exit_req;
  logic [63:0] mem_req_addr, exit_info1, exit_info2;
  logic [31:0] exit_code;
  int checks = 0, fails = 0;
  bit timeout = 0;

  always #2 clk = ~clk;

  io_perm_check uut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_hit(input logic [15:0] p, input logic [31:0] d, input logic [15:0] w);
    bit r = 0;
    for (int i = 0; i < int'(d[6:4]); i++) if (w[int'(p[2:0]) + i]) r = 1;
    return r;
  endfunction

  task automatic run_one(input logic [15:0] p, input logic [31:0] d, input logic [63:0] b,
                         input logic [63:0] n, input bit en, input logic [15:0] w,
                         input int rdly, input int sdly);
    bit h;
    @(negedge clk);
    port_num = p; access_desc = d; bitmap_base = b; next_ip = n; io_icpt_en = en; start = 1;
    @(negedge clk);
    start = 0;
    port_num = ~p; access_desc = ~d; bitmap_base = ~b; next_ip = ~n; io_icpt_en = ~en;
    if (!en) begin
      chk("R2 done", done, 1); chk("R2 exit", exit_req, 0);
      chk("R2 noreq", mem_req_valid, 0); chk("R2 info2", exit_info2, 0);
      @(negedge clk);
      chk("R6 done low", done, 0);
      return;
    end
    chk("R4 req up", mem_req_valid, 1);
    chk("R3 addr", mem_req_addr, b + 64'(p[15:3]));
    for (int i = 0; i < rdly; i++) begin
      @(negedge clk);
      chk("R4 held", mem_req_valid, 1);
      chk("R9 addr stable", mem_req_addr, b + 64'(p[15:3]));
    end
    mem_req_ready = 1;
    @(negedge clk);
    mem_req_ready = 0;
    chk("R4 req drop", mem_req_valid, 0);
    for (int i = 0; i < sdly; i++) begin
      start = (i == 0);
      @(negedge clk);
      start = 0;
      chk("R6 no early done", done, 0);
    end
    mem_rsp_valid = 1; mem_rsp_data = w;
    @(negedge clk);
    mem_rsp_valid = 0; mem_rsp_data = $urandom;
    h = exp_hit(p, d, w);
    chk("R6 done", done, 1);
    chk("R5 decision", exit_req, h);
    chk("R7 info1", exit_info1, h ? {32'h0, d | {p, 16'h0}} : 64'h0);
    chk("R8 info2", exit_info2, h ? n : 64'h0);
    chk("R8 code", exit_code, h ? 64'h7B : 64'h0);
    @(negedge clk);
    chk("R6 pulse", done, 0);
    chk("R9 idle", busy, 0);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    chk("R1 done", done, 0); chk("R1 busy", busy, 0);
    chk("R1 req", mem_req_valid, 0); chk("R1 exit", exit_req, 0);
    rst_n = 1;
    run_one(16'h0007, 32'h40, 64'h1000, 64'h55, 1, 16'h0400, 0, 0);
    run_one(16'h0007, 32'h40, 64'h1000, 64'h55, 1, 16'hF87F, 2, 1);
    run_one(16'h0003, 32'h00, 64'h2000, 64'h66, 1, 16'hFFFF, 1, 2);
    run_one(16'hFFFF, 32'h70, 64'hFFFF_0000, 64'h77, 1, 16'h4000, 3, 3);
    run_one(16'hFFFF, 32'h70, 64'hFFFF_0000, 64'h77, 1, 16'h007F, 0, 0);
    run_one(16'h1234, 32'h10, 64'h0, 64'h88, 0, 16'hFFFF, 0, 0);
    run_one(16'h0010, 32'hABCD_0010, 64'h300, 64'h99, 1, 16'h0001, 0, 5);
    for (int k = 0; k < 400; k++)
      run_one(16'($urandom), $urandom, {$urandom, $urandom}, {$urandom, $urandom},
              ($urandom % 5) != 0, 16'($urandom), $urandom % 4, $urandom % 4);
  endtask

  initial begin
    void'($urandom(32'd2024));
    fork
      run_all();
      begin repeat (150000) @(posedge clk); timeout = 1; end
    join_any
    if (timeout) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule